// File: doc/BRIEF.md
# Strap-Addressed SMBus Slave Interface

A slave-only SMBus/I2C target built to run on a fast system clock. SDA and SCL are sampled as plain inputs, synchronized and glitch-filtered. The block answers on the bus by pulling SDA low through an open-drain enable. It never drives SCL and never stretches the clock, and it keeps working at SCL rates of 100 kHz and above.

Its 7-bit address comes from a two-bit strap that picks one of three values. A mode input forces the lowest of the three regardless of the strap. The block accepts SMBus write-word and read-word transfers. It acknowledges every byte of a write-word addressed to it, whatever the command code. It stores the data only for a small window of command codes and silently drops the rest. Each stored write also pulses a strobe output carrying the command and the data word.

Any START or STOP pulls the protocol logic back to its entry point at once. An SCL line held low past a timeout does the same. A shutdown input holds the interface idle with SDA released.

Top module: `smb_strap_slave`

## Requirements
- R1: The 7-bit address follows the strap when the mode input is low: strap_i 2'b00 selects 0x09, 2'b01 selects 0x10, and 2'b10 or 2'b11 selects 0x14. In 8-bit form with R/W as bit 0 these are 0x12, 0x20 and 0x28.
- R2: With smart_mode_i high the address is 0x09 for every strap value, and the other two addresses get no ACK.
- R3: An address byte that does not match gets no ACK. SDA then stays released for the rest of that transfer, until the next START or STOP.
- R4: A write-word runs address(W), command, low byte, high byte, each sent MSB first. All four bytes are ACKed, unsupported command codes included. A fifth byte is not ACKed.
- R5: Only command codes CMD_BASE to CMD_BASE+NUM_REGS-1 (default 0x08 to 0x0B) update the register file. Such a write produces exactly one wr_stb_o pulse, with wr_cmd_o and wr_data_o holding the command and the {high,low} word. Any other command code changes no register and gives no pulse.
- R6: A read-word runs address(W), command, repeated START, address(R). The block then returns the stored word low byte first, MSB first within each byte. Unsupported command codes read as 0x0000.
- R7: A NACK from the master after a data byte ends the read. SDA stays released until the next START or STOP.
- R8: A START or STOP at any bit position aborts the transfer in progress. A write cut short before its high byte is complete commits nothing, and the following transfer is decoded from its address byte.
- R9: sda_oe_o changes only while SCL is low. The block has no SCL output.
- R10: When SCL stays low for TIMEOUT_CLKS system clocks, the block releases SDA and returns to idle. It then responds normally after the next START.
- R11: While shdn_i is high the block releases SDA within one clock and ACKs nothing. Stored register contents are kept.
- R12: After reset sda_oe_o and wr_stb_o are low and every register reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| strap_i | input | 2 | Address strap select |
| smart_mode_i | input | 1 | Forces address 0x09 |
| shdn_i | input | 1 | Holds the interface idle, SDA released |
| wr_stb_o | output | 1 | One-cycle pulse per committed write |
| wr_cmd_o | output | 8 | Command code of the committed write |
| wr_data_o | output | 16 | Data word of the committed write |

## Verification
The assertions assume that the master holds SDA steady while SCL is high, except for deliberate START and STOP. They also assume that every line edge is spaced further apart than the synchronizer plus filter delay. The R9 check further assumes that the master issues STOP only once the block has released SDA. The bench master keeps to this by changing SDA only a quarter period after SCL falls, with quarter periods longer than the filter window. It issues STOP and repeated START only after an ACK bit has been clocked out or after a NACKed byte. Timeouts and shutdown are only ever driven while SCL is low.

// File: rtl/smb_slv_pkg.sv
package smb_slv_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK, PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {ST_ADDR, ST_CMD, ST_D0, ST_D1} stage_e;

  localparam logic [6:0] ADDR_LO  = 7'h09;
  localparam logic [6:0] ADDR_MID = 7'h10;
  localparam logic [6:0] ADDR_HI  = 7'h14;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int NLINES   = 2,
  parameter int FILT_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] line_i,
  output logic [NLINES-1:0] line_o,
  output logic [NLINES-1:0] rise_o,
  output logic [NLINES-1:0] fall_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic          s1_q, s2_q, f_q, fd_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b1;
        s2_q  <= 1'b1;
        f_q   <= 1'b1;
        fd_q  <= 1'b1;
        cnt_q <= '0;
      end else begin
        s1_q <= line_i[g];
        s2_q <= s1_q;
        fd_q <= f_q;
        if (s2_q != f_q) begin
          // accept a new level only after it held FILT_LEN clocks
          if (cnt_q == CW'(FILT_LEN - 1)) begin
            f_q   <= s2_q;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end

    assign line_o[g] = f_q;
    assign rise_o[g] = f_q & ~fd_q;
    assign fall_o[g] = ~f_q & fd_q;
  end
endmodule

// File: rtl/smb_addr_sel.sv
module smb_addr_sel
  import smb_slv_pkg::*;
(
  input  logic [1:0] strap_i,
  input  logic       smart_i,
  output logic [6:0] addr_o
);
  always_comb begin
    if (smart_i) begin
      addr_o = ADDR_LO;
    end else begin
      unique case (strap_i)
        2'b00:   addr_o = ADDR_LO;
        2'b01:   addr_o = ADDR_MID;
        default: addr_o = ADDR_HI;
      endcase
    end
  end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int         NUM_REGS = 4,
  parameter logic [7:0] CMD_BASE = 8'h08
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  wr_cmd_i,
  input  logic [15:0] wr_data_i,
  input  logic [7:0]  rd_cmd_i,
  output logic [15:0] rd_data_o,
  output logic        wr_stb_o,
  output logic [7:0]  wr_cmd_o,
  output logic [15:0] wr_data_o
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [15:0] regs_q [NUM_REGS];
  logic [7:0]  wr_off, rd_off;
  logic        wr_hit, rd_hit;

  assign wr_off = wr_cmd_i - CMD_BASE;
  assign rd_off = rd_cmd_i - CMD_BASE;
  assign wr_hit = (wr_cmd_i >= CMD_BASE) && (32'(wr_off) < 32'(NUM_REGS));
  assign rd_hit = (rd_cmd_i >= CMD_BASE) && (32'(rd_off) < 32'(NUM_REGS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
      wr_stb_o  <= 1'b0;
      wr_cmd_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (wr_en_i && wr_hit) begin
        regs_q[wr_off[IW-1:0]] <= wr_data_i;
        wr_stb_o  <= 1'b1;
        wr_cmd_o  <= wr_cmd_i;
        wr_data_o <= wr_data_i;
      end
    end
  end

  assign rd_data_o = rd_hit ? regs_q[rd_off[IW-1:0]] : '0;

  // R5
  stb_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(wr_en_i));
endmodule

// File: rtl/smb_strap_slave.sv
module smb_strap_slave
  import smb_slv_pkg::*;
#(
  parameter int         FILT_LEN     = 4,
  parameter int         TIMEOUT_CLKS = 3_750_000,
  parameter int         NUM_REGS     = 4,
  parameter logic [7:0] CMD_BASE     = 8'h08
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [1:0]  strap_i,
  input  logic        smart_mode_i,
  input  logic        shdn_i,
  output logic        wr_stb_o,
  output logic [7:0]  wr_cmd_o,
  output logic [15:0] wr_data_o
);
  localparam int TW = $clog2(TIMEOUT_CLKS + 1);

  logic [1:0] ln, rs, fl;
  logic       scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] my_addr;

  smb_line_filter #(.NLINES(2), .FILT_LEN(FILT_LEN)) u_filt (
    .clk_i, .rst_ni, .line_i({scl_i, sda_i}),
    .line_o(ln), .rise_o(rs), .fall_o(fl)
  );

  assign {scl_f, sda_f} = ln;
  assign scl_rise  = rs[1];
  assign scl_fall  = fl[1];
  assign start_det = fl[0] & scl_f & ~scl_rise;
  assign stop_det  = rs[0] & scl_f & ~scl_rise;

  smb_addr_sel u_addr (.strap_i, .smart_i(smart_mode_i), .addr_o(my_addr));

  // stuck-low watchdog on the filtered clock line
  logic [TW-1:0] to_cnt_q;
  logic          hung;
  assign hung = (to_cnt_q == TW'(TIMEOUT_CLKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    to_cnt_q <= '0;
    else if (scl_f) to_cnt_q <= '0;
    else if (!hung) to_cnt_q <= to_cnt_q + 1'b1;
  end

  phase_e      phase_q;
  stage_e      stage_q;
  logic [3:0]  bit_cnt_q;
  logic [7:0]  sh_q, tx_q, rd_hi_q, cmd_q, dlo_q;
  logic [15:0] wdata_q, rd_data;
  logic        rw_q, sda_oe_q, wr_en_q, mack_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      stage_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      rd_hi_q   <= '0;
      cmd_q     <= '0;
      dlo_q     <= '0;
      wdata_q   <= '0;
      rw_q      <= 1'b0;
      sda_oe_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      mack_ok_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (shdn_i || hung) begin
        phase_q  <= PH_IDLE;
        sda_oe_q <= 1'b0;
      end else if (start_det) begin
        phase_q   <= PH_RX;
        stage_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        sda_oe_q  <= 1'b0;
      end else if (stop_det) begin
        phase_q  <= PH_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_RX: begin
            if (scl_rise) begin
              sh_q      <= {sh_q[6:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              phase_q   <= PH_ACK;
              sda_oe_q  <= 1'b1;
              unique case (stage_q)
                ST_ADDR: begin
                  rw_q <= sh_q[0];
                  if (sh_q[7:1] != my_addr) begin
                    phase_q  <= PH_SKIP;
                    sda_oe_q <= 1'b0;
                  end
                end
                ST_CMD: cmd_q <= sh_q;
                ST_D0:  dlo_q <= sh_q;
                ST_D1: begin
                  wdata_q <= {sh_q, dlo_q};
                  wr_en_q <= 1'b1;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              sda_oe_q <= 1'b0;
              unique case (stage_q)
                ST_ADDR: begin
                  if (rw_q) begin
                    phase_q   <= PH_TX;
                    stage_q   <= ST_D0;
                    tx_q      <= rd_data[7:0];
                    rd_hi_q   <= rd_data[15:8];
                    sda_oe_q  <= ~rd_data[7];
                    bit_cnt_q <= '0;
                  end else begin
                    phase_q <= PH_RX;
                    stage_q <= ST_CMD;
                  end
                end
                ST_CMD: begin phase_q <= PH_RX; stage_q <= ST_D0; end
                ST_D0:  begin phase_q <= PH_RX; stage_q <= ST_D1; end
                ST_D1:  phase_q <= PH_SKIP;
              endcase
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bit_cnt_q == 4'd7) begin
                sda_oe_q  <= 1'b0;
                phase_q   <= PH_MACK;
                bit_cnt_q <= '0;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                tx_q      <= {tx_q[6:0], 1'b0};
                sda_oe_q  <= ~tx_q[6];
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              mack_ok_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_ok_q && stage_q == ST_D0) begin
                stage_q   <= ST_D1;
                phase_q   <= PH_TX;
                tx_q      <= rd_hi_q;
                sda_oe_q  <= ~rd_hi_q[7];
                bit_cnt_q <= '0;
              end else begin
                phase_q <= PH_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  smb_regfile #(.NUM_REGS(NUM_REGS), .CMD_BASE(CMD_BASE)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en_q), .wr_cmd_i(cmd_q), .wr_data_i(wdata_q),
    .rd_cmd_i(cmd_q), .rd_data_o(rd_data),
    .wr_stb_o, .wr_cmd_o, .wr_data_o
  );

  assign sda_oe_o = sda_oe_q;

  // R8
  start_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !shdn_i && !hung) |=> (phase_q == PH_RX && stage_q == ST_ADDR && !sda_oe_q));
  // R8
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (phase_q == PH_IDLE && !sda_oe_q));
  // R9
  oe_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) |-> ($past(scl_fall) || $past(start_det) ||
      $past(stop_det) || $past(shdn_i) || $past(hung)));
  // R10
  hung_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hung |=> !sda_oe_q);
  // R11
  shdn_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> !sda_oe_q);
  // R3
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SKIP) |-> !sda_oe_q);
endmodule

// File: tb/smb_strap_slave_tb.sv
module smb_strap_slave_tb;
  localparam int Q  = 10;
  localparam int TO = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic smart = 1'b0, shdn = 1'b0;
  logic sda_oe, wr_stb;
  logic [7:0] wr_cmd;
  logic [15:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  smb_strap_slave #(.FILT_LEN(4), .TIMEOUT_CLKS(TO), .NUM_REGS(4), .CMD_BASE(8'h08)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .smart_mode_i(smart), .shdn_i(shdn),
    .wr_stb_o(wr_stb), .wr_cmd_o(wr_cmd), .wr_data_o(wr_data)
  );

  int total = 0, errors = 0, stb_cnt = 0, r9_bad = 0;
  logic [7:0] last_cmd;
  logic [15:0] last_data;
  logic oe_prev = 1'b0;
  logic [15:0] mdl [4];

  always @(posedge clk) begin
    if (wr_stb) begin
      stb_cnt++;
      last_cmd  = wr_cmd;
      last_data = wr_data;
    end
    if (rst_n && sda_oe != oe_prev && scl_m) r9_bad++;
    oe_prev = sda_oe;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  function automatic logic [6:0] strap_addr(input logic [1:0] s, input logic sm);
    if (sm) return 7'h09;
    case (s)
      2'b00:   return 7'h09;
      2'b01:   return 7'h10;
      default: return 7'h14;
    endcase
  endfunction

  function automatic bit supported(input logic [7:0] c);
    return c >= 8'h08 && c <= 8'h0B;
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] c);
    return supported(c) ? mdl[c - 8'h08] : 16'h0000;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(2 * Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_line; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic nk;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nk);
    ack = ~nk;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic nak);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nak);
  endtask

  task automatic wr_word(input logic [6:0] a, input logic [7:0] c, input logic [15:0] d,
                         output logic [3:0] acks);
    bus_start();
    put_byte({a, 1'b0}, acks[3]);
    put_byte(c, acks[2]);
    put_byte(d[7:0], acks[1]);
    put_byte(d[15:8], acks[0]);
    bus_stop();
  endtask

  task automatic rd_word(input logic [6:0] a, input logic [7:0] c, output logic [15:0] d);
    logic k;
    bus_start();
    put_byte({a, 1'b0}, k);
    put_byte(c, k);
    bus_start();
    put_byte({a, 1'b1}, k);
    get_byte(d[7:0], 1'b0);
    get_byte(d[15:8], 1'b1);
    bus_stop();
  endtask

  initial begin
    logic [3:0] acks;
    logic [15:0] rd;
    logic ak;
    int s0;
    s0 = $urandom(32'h5eed);
    for (int i = 0; i < 4; i++) mdl[i] = 16'h0000;
    wt(5); rst_n = 1'b1; wt(5);

    // R12 reset state
    check(sda_oe == 1'b0 && wr_stb == 1'b0, "R12 outputs", {sda_oe, wr_stb}, 0);
    for (int c = 8; c < 12; c++) begin
      rd_word(7'h09, 8'(c), rd);
      check(rd == 16'h0000, "R12 reg reset", rd, 0);
    end

    // R1 strap decode
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int a = 0; a < 3; a++) begin
        logic [6:0] ad;
        ad = (a == 0) ? 7'h09 : (a == 1) ? 7'h10 : 7'h14;
        bus_start(); put_byte({ad, 1'b0}, ak); bus_stop();
        check(ak == (ad == strap_addr(2'(s), 1'b0)), "R1 strap ack", ak, ad);
      end
    end

    // R2 mode override
    smart = 1'b1; strap = 2'b01;
    bus_start(); put_byte({7'h09, 1'b0}, ak); bus_stop();
    check(ak == 1'b1, "R2 forced addr ack", ak, 1);
    bus_start(); put_byte({7'h10, 1'b0}, ak); bus_stop();
    check(ak == 1'b0, "R2 strap addr ignored", ak, 0);
    smart = 1'b0; strap = 2'b00;

    // R4/R5 supported write
    wr_word(7'h09, 8'h09, 16'hA55A, acks); mdl[1] = 16'hA55A;
    check(acks == 4'hF, "R4 acks", acks, 4'hF);
    check(stb_cnt == 5 - 4 && last_cmd == 8'h09 && last_data == 16'hA55A, "R5 strobe",
          {stb_cnt[7:0], last_cmd, last_data}, {8'd1, 8'h09, 16'hA55A});
    rd_word(7'h09, 8'h09, rd);
    check(rd == 16'hA55A, "R6 readback", rd, 16'hA55A);

    // R4/R5 unsupported write acked, discarded
    wr_word(7'h09, 8'h30, 16'h1234, acks);
    check(acks == 4'hF, "R4 unsupported acked", acks, 4'hF);
    check(stb_cnt == 1, "R5 no strobe", stb_cnt, 1);
    rd_word(7'h09, 8'h30, rd);
    check(rd == 16'h0000, "R6 unsupported reads zero", rd, 0);

    // R4 fifth byte not acked
    bus_start(); put_byte(8'h12, ak); put_byte(8'h08, ak);
    put_byte(8'h11, ak); put_byte(8'h22, ak); put_byte(8'h33, ak); bus_stop();
    mdl[0] = 16'h2211;
    check(ak == 1'b0, "R4 extra byte nack", ak, 0);

    // R3 mismatched address: silent for rest
    bus_start(); put_byte({7'h14, 1'b0}, ak); put_byte(8'h0A, acks[2]);
    put_byte(8'h55, acks[1]); put_byte(8'h66, acks[0]); bus_stop();
    check({ak, acks[2:0]} == 4'h0 && stb_cnt == 2, "R3 ignored", {ak, acks[2:0]}, 0);

    // R8 START mid high byte aborts write
    bus_start(); put_byte(8'h12, ak); put_byte(8'h0A, ak); put_byte(8'h77, ak);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start(); put_byte(8'h12, ak); put_byte(8'h0B, ak);
    put_byte(8'hCD, ak); put_byte(8'hAB, ak); bus_stop();
    mdl[3] = 16'hABCD;
    rd_word(7'h09, 8'h0A, rd);
    check(rd == 16'h0000, "R8 aborted write", rd, 0);
    rd_word(7'h09, 8'h0B, rd);
    check(rd == 16'hABCD, "R8 after restart", rd, 16'hABCD);
    // R8 STOP mid byte
    bus_start(); put_byte(8'h12, ak); put_bit(1'b0); put_bit(1'b0); bus_stop();
    bus_start(); put_byte(8'h12, ak); bus_stop();
    check(ak == 1'b1, "R8 after stop", ak, 1);

    // R7 master NACK after low byte
    bus_start(); put_byte(8'h12, ak); put_byte(8'h09, ak);
    bus_start(); put_byte(8'h13, ak); get_byte(rd[7:0], 1'b1);
    check(rd[7:0] == 8'h5A, "R7 low byte", rd[7:0], 8'h5A);
    begin
      logic [8:0] tail;
      for (int i = 0; i < 9; i++) get_bit(tail[i]);
      check(tail == 9'h1FF, "R7 released after nack", tail, 9'h1FF);
    end
    bus_stop();

    // R10 stuck-low timeout during ACK
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(ak == 1'b1 ? 8'h12 >> i : 8'h12 >> i);
    check(sda_oe == 1'b1, "R10 ack driven", sda_oe, 1);
    wt(TO + 50);
    check(sda_oe == 1'b0, "R10 timeout release", sda_oe, 0);
    bus_stop();
    wr_word(7'h09, 8'h08, 16'h0F0F, acks); mdl[0] = 16'h0F0F;
    check(acks == 4'hF, "R10 recovered", acks, 4'hF);

    // R11 shutdown
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(1'(8'h12 >> i));
    check(sda_oe == 1'b1, "R11 ack driven", sda_oe, 1);
    shdn = 1'b1; wt(2);
    check(sda_oe == 1'b0, "R11 released", sda_oe, 0);
    bus_stop();
    bus_start(); put_byte(8'h12, ak); bus_stop();
    check(ak == 1'b0, "R11 no ack", ak, 0);
    shdn = 1'b0; wt(4);
    rd_word(7'h09, 8'h0B, rd);
    check(rd == 16'hABCD, "R11 contents kept", rd, 16'hABCD);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [7:0] c;
      logic [15:0] d;
      c = 8'h06 + 8'($urandom_range(7, 0));
      d = 16'($urandom);
      if ($urandom_range(1, 0) == 1) begin
        wr_word(7'h09, c, d, acks);
        if (supported(c)) mdl[c - 8'h08] = d;
        check(acks == 4'hF, "R4 random write", acks, 4'hF);
      end else begin
        rd_word(7'h09, c, rd);
        check(rd == exp_read(c), "R6 random read", rd, exp_read(c));
      end
    end
    for (int c = 8; c < 12; c++) begin
      rd_word(7'h09, 8'(c), rd);
      check(rd == exp_read(8'(c)), "R5 final contents", rd, exp_read(8'(c)));
    end

    check(r9_bad == 0, "R9 oe change with scl high", r9_bad, 0);
    finish_run();
  end
endmodule